// File: doc/BRIEF.md
# Sequencer Result FIFO Bank with Sticky Underflow Flags

This block holds four independent first-in first-out queues, one per sample sequencer. A producer pushes result words into each queue, and a bus reader pops them. When the reader pops a queue that holds nothing, the block does three things:

- it returns an all-zero word;
- it leaves both of that queue's pointers where they were;
- it latches a sticky flag for that queue.

The four flags are gathered into one 32-bit status word. Software reads this word through a simple strobe-based register port and clears a flag by writing a 1 to its bit.

Each queue keeps read and write pointers that are one bit wider than the entry index. That extra bit separates a full queue from an empty one. Pushes into a full queue are dropped. A pop returns its word on the cycle after the pop strobe. A register read likewise returns on the cycle after the read strobe, and it changes no state.

Top module: `ufb_fifo_bank`

## Requirements
- R1: After reset every queue reports empty, all pop data lanes are zero, and the status word reads 0.
- R2: A pop of a non-empty queue returns that queue's oldest entry on its data lane one cycle after the pop strobe, and entries leave in the order they were pushed.
- R3: A queue holds 8 entries. A push while it is full is dropped, and the stored entries are unchanged.
- R4: A pop of an empty queue sets the status bit whose index equals the queue number (bit 0 for queue 0 through bit 3 for queue 3). No other bit changes.
- R5: A pop of an empty queue returns an all-zero word on that queue's lane one cycle after the strobe.
- R6: A pop of an empty queue moves neither pointer. The queue stays empty, and the next pushed word is the next one popped.
- R7: A register write at offset 0x018 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 are kept.
- R8: If a flag is set by an underflow and cleared by a write in the same cycle, the flag ends up set.
- R9: Status bits 31 down to 4 always read 0. A read at any offset other than 0x018 returns 0, and a write there changes no flag.
- R10: A status read returns the flags one cycle after the read strobe and has no side effect: repeated reads return the same value.
- R11: Flags are independent. Underflow on one queue never sets another queue's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push | input | 4 | Per-queue push strobe |
| push_data | input | 128 | Push words, queue i on bits [32i+31:32i] |
| pop | input | 4 | Per-queue pop strobe |
| pop_data | output | 128 | Popped words, registered, queue i on bits [32i+31:32i] |
| fifo_empty | output | 4 | Per-queue empty indication |
| fifo_full | output | 4 | Per-queue full indication |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |

## Verification
The two functions that can land on one flag in the same cycle are the underflow set from an empty pop and the write-1-to-clear from the register port. The bench provokes this by driving a pop of empty queue 3 and a write of 1 to bit 3 at offset 0x018 on the same clock edge. It judges the result by reading the status word afterwards, where bit 3 must still be 1. A following write on its own must then clear that bit. A second collision case writes 0 to a set flag while a different queue underflows, and expects both flags to be set afterwards.

// File: rtl/ufb_pkg.sv
package ufb_pkg;
   localparam int unsigned REG_W = 32;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ufb_fifo.sv
module ufb_fifo #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] pop_data,
   output logic          empty,
   output logic          full,
   output logic          underflow
);
   localparam int unsigned PW = $clog2(DEPTH);

   logic [PW:0]   wr_ptr, rd_ptr;
   logic [DW-1:0] mem [DEPTH];
   logic          do_wr, do_rd;

   initial begin
      assert (ufb_pkg::is_pow2(DEPTH)) else $error("ufb_fifo: DEPTH must be a power of two >= 2");
      assert (DW >= 1) else $error("ufb_fifo: DW must be positive");
   end

   assign empty     = (wr_ptr == rd_ptr);
   assign full      = (wr_ptr[PW] != rd_ptr[PW]) && (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);
   assign do_wr     = push && !full;
   assign do_rd     = pop && !empty;
   assign underflow = pop && empty;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr[PW-1:0]] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         pop_data <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + 1'b1;
         if (do_rd) rd_ptr <= rd_ptr + 1'b1;
         if (pop)   pop_data <= empty ? '0 : mem[rd_ptr[PW-1:0]];
      end
   end
endmodule

// File: rtl/ufb_status.sv
module ufb_status #(
   parameter int unsigned         N      = 4,
   parameter int unsigned         AW     = 12,
   parameter logic [AW-1:0]       OFFSET = 12'h018
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N-1:0]               set,
   input  logic                       reg_wr,
   input  logic                       reg_rd,
   input  logic [AW-1:0]              reg_addr,
   input  logic [ufb_pkg::REG_W-1:0]  reg_wdata,
   output logic [ufb_pkg::REG_W-1:0]  reg_rdata,
   output logic [N-1:0]               flags
);
   localparam int unsigned RW = ufb_pkg::REG_W;

   logic          hit;
   logic [N-1:0]  clr;
   logic [RW-1:0] view;

   initial begin
      assert (N >= 1 && N < RW) else $error("ufb_status: N must be in 1..31");
   end

   assign hit  = (reg_addr == OFFSET);
   assign clr  = (reg_wr && hit) ? reg_wdata[N-1:0] : '0;
   assign view = {{(RW-N){1'b0}}, flags};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags     <= '0;
         reg_rdata <= '0;
      end else begin
         flags <= (flags & ~clr) | set;
         if (reg_rd) reg_rdata <= hit ? view : '0;
      end
   end
endmodule

// File: rtl/ufb_fifo_bank.sv
module ufb_fifo_bank #(
   parameter int unsigned   N_FIFOS       = 4,
   parameter int unsigned   DEPTH         = 8,
   parameter int unsigned   DW            = 32,
   parameter int unsigned   AW            = 12,
   parameter logic [AW-1:0] STATUS_OFFSET = 12'h018
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_FIFOS-1:0]    push,
   input  logic [N_FIFOS*DW-1:0] push_data,
   input  logic [N_FIFOS-1:0]    pop,
   output logic [N_FIFOS*DW-1:0] pop_data,
   output logic [N_FIFOS-1:0]    fifo_empty,
   output logic [N_FIFOS-1:0]    fifo_full,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [AW-1:0]         reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata
);
   logic [N_FIFOS-1:0] uf_set;
   logic [N_FIFOS-1:0] uf_flags;

   initial begin
      assert (N_FIFOS >= 1 && N_FIFOS <= 31) else $error("ufb_fifo_bank: N_FIFOS out of range");
      assert (STATUS_OFFSET[1:0] == 2'b00) else $error("ufb_fifo_bank: offset must be word aligned");
   end

   for (genvar g = 0; g < N_FIFOS; g++) begin : g_q
      ufb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_q (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (push[g]),
         .push_data (push_data[g*DW +: DW]),
         .pop       (pop[g]),
         .pop_data  (pop_data[g*DW +: DW]),
         .empty     (fifo_empty[g]),
         .full      (fifo_full[g]),
         .underflow (uf_set[g])
      );
   end

   ufb_status #(.N(N_FIFOS), .AW(AW), .OFFSET(STATUS_OFFSET)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .set       (uf_set),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .flags     (uf_flags)
   );
endmodule

// File: rtl/ufb_checker.sv
module ufb_checker #(
   parameter int unsigned   N_FIFOS       = 4,
   parameter int unsigned   DW            = 32,
   parameter int unsigned   AW            = 12,
   parameter logic [AW-1:0] STATUS_OFFSET = 12'h018
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [N_FIFOS-1:0]    push,
   input logic [N_FIFOS-1:0]    pop,
   input logic [N_FIFOS*DW-1:0] pop_data,
   input logic [N_FIFOS-1:0]    fifo_empty,
   input logic [N_FIFOS-1:0]    fifo_full,
   input logic                  reg_wr,
   input logic [AW-1:0]         reg_addr,
   input logic [31:0]           reg_wdata,
   input logic [31:0]           reg_rdata,
   input logic [N_FIFOS-1:0]    uf_flags
);
   assert_high_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata >> N_FIFOS) == 32'd0);

   for (genvar g = 0; g < N_FIFOS; g++) begin : g_chk
      assert_underflow_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (pop[g] && fifo_empty[g]) |=> uf_flags[g]);

      assert_underflow_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (pop[g] && fifo_empty[g]) |=> (pop_data[g*DW +: DW] == '0));

      assert_underflow_keeps_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (pop[g] && fifo_empty[g] && !push[g]) |=> fifo_empty[g]);

      assert_full_push_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (fifo_full[g] && push[g] && !pop[g]) |=> fifo_full[g]);

      assert_write0_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (uf_flags[g] && !(reg_wr && reg_addr == STATUS_OFFSET && reg_wdata[g])) |=> uf_flags[g]);

      assert_clear_without_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_addr == STATUS_OFFSET && reg_wdata[g] && !(pop[g] && fifo_empty[g])) |=> !uf_flags[g]);

      assert_no_spurious_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (!uf_flags[g] && !(pop[g] && fifo_empty[g])) |=> !uf_flags[g]);
   end
endmodule

bind ufb_fifo_bank ufb_checker #(
   .N_FIFOS(N_FIFOS), .DW(DW), .AW(AW), .STATUS_OFFSET(STATUS_OFFSET)
) u_ufb_checker (
   .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .pop_data(pop_data),
   .fifo_empty(fifo_empty), .fifo_full(fifo_full), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .uf_flags(uf_flags)
);

// File: tb/test_ufb_fifo_bank.sv
module test_ufb_fifo_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NF = 4;
   localparam int DW = 32;
   localparam logic [11:0] OFF = 12'h018;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NF-1:0]    push = '0;
   logic [NF*DW-1:0] push_data = '0;
   logic [NF-1:0]    pop = '0;
   logic [NF*DW-1:0] pop_data;
   logic [NF-1:0]    fifo_empty, fifo_full;
   logic             reg_wr = 1'b0, reg_rd = 1'b0;
   logic [11:0]      reg_addr = '0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ufb_fifo_bank i_ufb_fifo_bank (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
      .pop(pop), .pop_data(pop_data), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_push(input int f, input logic [31:0] d);
      push[f] = 1'b1;
      push_data[f*DW +: DW] = d;
      @(negedge clk);
      push[f] = 1'b0;
   endtask

   task automatic do_pop(input int f, output logic [31:0] d);
      pop[f] = 1'b1;
      @(negedge clk);
      pop[f] = 1'b0;
      d = pop_data[f*DW +: DW];
   endtask

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] s;
      chk("R1 empty", {28'd0, fifo_empty}, 32'hF);
      chk("R1 pop_data", {31'd0, (pop_data == '0)}, 32'd1);
      reg_read(OFF, s);
      chk("R1 status", s, 32'd0);
   endtask

   task automatic t_order();
      logic [31:0] d;
      for (int i = 0; i < 3; i++) do_push(1, 32'hA000_0000 + i);
      for (int i = 0; i < 3; i++) begin
         do_pop(1, d);
         chk("R2 order", d, 32'hA000_0000 + i);
      end
      chk("R2 empty after drain", {31'd0, fifo_empty[1]}, 32'd1);
   endtask

   task automatic t_full();
      logic [31:0] d;
      for (int i = 0; i < 9; i++) do_push(2, 32'hB000_0000 + i);
      chk("R3 full", {31'd0, fifo_full[2]}, 32'd1);
      for (int i = 0; i < 8; i++) begin
         do_pop(2, d);
         chk("R3 kept entries", d, 32'hB000_0000 + i);
      end
      do_pop(2, d);
      chk("R5 zero after drain", d, 32'd0);
   endtask

   task automatic t_underflow();
      logic [31:0] d, s;
      reg_write(OFF, 32'hF);
      do_pop(0, d);
      chk("R5 zero word", d, 32'd0);
      reg_read(OFF, s);
      chk("R4 R11 only bit0", s, 32'h1);
      chk("R6 still empty", {31'd0, fifo_empty[0]}, 32'd1);
      do_push(0, 32'hC0FF_EE01);
      do_pop(0, d);
      chk("R6 next word", d, 32'hC0FF_EE01);
      chk("R6 empty again", {31'd0, fifo_empty[0]}, 32'd1);
   endtask

   task automatic t_w1c();
      logic [31:0] d, s;
      do_pop(2, d);
      reg_read(OFF, s);
      chk("R4 bits0,2", s, 32'h5);
      reg_write(OFF, 32'h0);
      reg_read(OFF, s);
      chk("R7 write0 keeps", s, 32'h5);
      reg_read(OFF, s);
      chk("R10 repeat read", s, 32'h5);
      reg_write(12'h01C, 32'hFFFF_FFFF);
      reg_read(OFF, s);
      chk("R9 other offset write", s, 32'h5);
      reg_read(12'h01C, s);
      chk("R9 other offset read", s, 32'd0);
      reg_write(OFF, 32'h4);
      reg_read(OFF, s);
      chk("R7 clear bit2", s, 32'h1);
      reg_write(OFF, 32'hFFFF_FFFF);
      reg_read(OFF, s);
      chk("R9 R7 all clear", s, 32'd0);
   endtask

   task automatic t_collide();
      logic [31:0] s;
      pop[3] = 1'b1;
      reg_wr = 1'b1; reg_addr = OFF; reg_wdata = 32'h8;
      @(negedge clk);
      pop[3] = 1'b0; reg_wr = 1'b0;
      reg_read(OFF, s);
      chk("R8 set wins", s, 32'h8);
      pop[1] = 1'b1;
      reg_wr = 1'b1; reg_addr = OFF; reg_wdata = 32'h0;
      @(negedge clk);
      pop[1] = 1'b0; reg_wr = 1'b0;
      reg_read(OFF, s);
      chk("R8 R7 keep and set", s, 32'hA);
      reg_write(OFF, 32'hA);
      reg_read(OFF, s);
      chk("R7 clear after collide", s, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order();
      t_full();
      t_underflow();
      t_w1c();
      t_collide();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1..all actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule